// File: doc/BRIEF.md
# Line-Interleaved Window Store with Vertical Alignment

This block keeps a search window of 48 lines in 16 memory banks. Line `L` is stored in bank `L mod 16`, inside region `L / 16` of that bank, so each bank holds three lines that lie 16 apart. A read request names a starting line and a column. The block returns the sixteen consecutive lines that begin at that starting line, all from that column, as sixteen 16-bit words in one cycle.

The starting line sets two values. The base region is `start / 16` and the rotate amount is `start mod 16`. Banks whose index is below the rotate amount have already wrapped past the start, so they read the next region up. All other banks read the base region. The sixteen bank outputs then pass through a rotator built from one 16-position rotator per data bit. After the rotator, output word `k` holds window line `start + k`.

The banks have a simple write port addressed by window line and column. A search engine uses it to fill the window before it starts reading.

Top module: `linebank_rotator`

## Requirements
- R1: A word written to window line L (0..47) at column c is later returned as output word k of any in-range read with start line L-k at column c. Output word k occupies bits [16k+15:16k] of `rd_data`.
- R2: For a start line s that is not a multiple of 16, banks below s mod 16 supply data from region s/16 + 1 and the remaining banks supply data from region s/16. Every in-range start line from 0 to 32 returns lines s..s+15 in order.
- R3: For start lines 0, 16 and 32 the rotate amount is zero, and all banks read the same region, which is s/16.
- R4: Output word 0 of an in-range read always holds window line s, at every rotate amount from 0 to 15.
- R5: `rd_valid` is high exactly in the cycle after a cycle with `rd_en` high, and low after any cycle without a request.
- R6: A request with a start line above 32, including the unused codes 48..63, gives `rd_valid`=1 and `rd_oor`=1 with all 256 data bits zero. An in-range request gives `rd_oor`=0. `rd_oor` is 0 whenever `rd_valid` is 0.
- R7: When a write and a read hit the same bank location in the same cycle, the read returns the value held before the write. The following read returns the new value.
- R8: While `rst_n` is low at a clock edge, `rd_valid` and `rd_oor` go to 0, even if `rd_en` is high.
- R9: Back-to-back reads with a different start line in every cycle are each aligned with their own rotate amount.
- R10: A write to window line 48..63 changes no stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_line | input | 6 | Window line to write |
| wr_col | input | 5 | Column to write |
| wr_data | input | 16 | Word to write |
| rd_en | input | 1 | Read request |
| rd_line | input | 6 | Starting window line of the read |
| rd_col | input | 5 | Column of the read |
| rd_valid | output | 1 | Read result present this cycle |
| rd_oor | output | 1 | Result belongs to an out-of-range request |
| rd_data | output | 256 | Sixteen aligned words, word k = line start+k |

## Verification
The hardest case to reach from the ports is a read whose bank location is being rewritten in the same cycle. It can only be seen if both the write and the read land on the same bank, the same region and the same column, and the read's split between regions has to place that line in the region being written. The bench first fills every line with a distinct value. It then issues paired cycles in which the written line is chosen as start+k for a known k, and follows each with a repeat read. In this way both the old-value and the new-value outcomes are compared. Mixed random traffic later revisits the 32/33 boundary and every rotate amount in back-to-back cycles.

// File: rtl/linebank_pkg.sv
// Package: shared defaults and the registered read-status record for the
// banked line store. Assumes the geometry used by every module below.
package linebank_pkg;
    localparam int LB_BANKS   = 16;
    localparam int LB_WORD_W  = 16;
    localparam int LB_REGIONS = 3;
    localparam int LB_COLS    = 32;

    typedef struct packed {
        logic valid;
        logic oor;
    } rd_status_t;
endpackage

// File: rtl/linebank_addr_gen.sv
// Module: linebank_addr_gen
// Splits a starting line into a base region and a rotate amount. It also
// builds one read address per bank: banks below the rotate amount take the
// next region. It flags starts whose 16-line span runs past the last
// region. Assumes NUM_BANKS is a power of two.
module linebank_addr_gen #(
    parameter int NUM_BANKS   = 16,
    parameter int NUM_REGIONS = 3,
    parameter int NUM_COLS    = 32,
    parameter int LINE_W      = 6,
    parameter int COL_W       = 5,
    parameter int ROT_W       = 4,
    parameter int ADDR_W      = 7
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                req,
    input  logic [LINE_W-1:0]                   start_line,
    input  logic [COL_W-1:0]                    col,
    output logic [ROT_W-1:0]                    rot,
    output logic                                oor,
    output logic [NUM_BANKS-1:0]                next_mask,
    output logic [NUM_BANKS-1:0][ADDR_W-1:0]    bank_addr
);
    localparam int REG_W      = LINE_W - ROT_W;
    localparam int LAST_START = (NUM_REGIONS - 1) * NUM_BANKS;

    logic [REG_W:0] base_region;
    logic [REG_W:0] next_region;

    // Purpose: split the start line and decide the range flag.
    always_comb begin
        rot         = start_line[ROT_W-1:0];
        base_region = {1'b0, start_line[LINE_W-1:ROT_W]};
        next_region = base_region + 1'b1;
        oor         = (int'(start_line) > LAST_START);
    end

    // Purpose: choose a region per bank and form its flat address.
    always_comb begin
        for (int b = 0; b < NUM_BANKS; b++) begin
            next_mask[b] = (ROT_W'(b) < rot);
            bank_addr[b] = ADDR_W'(next_mask[b] ? next_region : base_region)
                           * ADDR_W'(NUM_COLS) + ADDR_W'(col);
        end
    end

    // The number of banks sent to the next region equals the rotate amount.
    assert_split_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !oor) |-> ($countones(next_mask) == int'(rot)));

    // An aligned start sends one address to all banks.
    assert_single_region_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req && rot == '0) |-> (next_mask == '0 && bank_addr[0] == bank_addr[NUM_BANKS-1]));
endmodule

// File: rtl/linebank_bank.sv
// Module: linebank_bank
// A single memory bank with one write port and one registered read port.
// A same-address read and write return the old word. The storage is not
// reset; the caller fills it before reading.
module linebank_bank #(
    parameter int WORD_W = 16,
    parameter int DEPTH  = 96,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] mem [DEPTH];

    // Purpose: store a word on a write strobe.
    always_ff @(posedge clk) begin
        if (we && int'(waddr) < DEPTH) begin
            mem[waddr] <= wdata;
        end
    end

    // Purpose: registered read; returns the value from before a same-cycle write.
    always_ff @(posedge clk) begin
        if (re && int'(raddr) < DEPTH) begin
            rdata <= mem[raddr];
        end
    end
endmodule

// File: rtl/linebank_vrot.sv
// Module: linebank_vrot
// Rotator built as one NUM_BANKS-position rotator per data bit. Output
// word k takes input word (k + rot) mod NUM_BANKS. Purely combinational.
module linebank_vrot #(
    parameter int NUM_BANKS = 16,
    parameter int WORD_W    = 16,
    parameter int ROT_W     = 4
) (
    input  logic [NUM_BANKS-1:0][WORD_W-1:0] din,
    input  logic [ROT_W-1:0]                 rot,
    output logic [NUM_BANKS-1:0][WORD_W-1:0] dout
);
    for (genvar j = 0; j < WORD_W; j++) begin : g_slice
        logic [NUM_BANKS-1:0]   s_in;
        logic [NUM_BANKS-1:0]   s_out;
        logic [2*NUM_BANKS-1:0] s_dbl;

        for (genvar k = 0; k < NUM_BANKS; k++) begin : g_gather
            assign s_in[k] = din[k][j];
        end

        // Purpose: doubled vector shifted down gives a circular rotation.
        assign s_dbl = {s_in, s_in} >> rot;
        assign s_out = s_dbl[NUM_BANKS-1:0];

        for (genvar k = 0; k < NUM_BANKS; k++) begin : g_scatter
            assign dout[k][j] = s_out[k];
        end
    end
endmodule

// File: rtl/linebank_rotator.sv
// Module: linebank_rotator (top)
// A 48-line window store spread over 16 line-interleaved banks. A read
// returns 16 consecutive lines from one column, aligned so that word 0 is
// the start line, one cycle after the request. The rotate amount is
// registered together with the bank read so that both describe the same
// request. Out-of-range requests return zeros with a flag.
module linebank_rotator
    import linebank_pkg::*;
#(
    parameter int NUM_BANKS   = LB_BANKS,
    parameter int WORD_W      = LB_WORD_W,
    parameter int NUM_REGIONS = LB_REGIONS,
    parameter int NUM_COLS    = LB_COLS,
    localparam int LINE_W     = $clog2(NUM_BANKS * NUM_REGIONS),
    localparam int COL_W      = $clog2(NUM_COLS),
    localparam int ROT_W      = $clog2(NUM_BANKS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [LINE_W-1:0]           wr_line,
    input  logic [COL_W-1:0]            wr_col,
    input  logic [WORD_W-1:0]           wr_data,
    input  logic                        rd_en,
    input  logic [LINE_W-1:0]           rd_line,
    input  logic [COL_W-1:0]            rd_col,
    output logic                        rd_valid,
    output logic                        rd_oor,
    output logic [NUM_BANKS*WORD_W-1:0] rd_data
);
    localparam int DEPTH     = NUM_REGIONS * NUM_COLS;
    localparam int ADDR_W    = $clog2(DEPTH);
    localparam int NUM_LINES = NUM_BANKS * NUM_REGIONS;

    logic [ROT_W-1:0]                  req_rot;
    logic                              req_oor;
    logic [NUM_BANKS-1:0]              req_next_mask;
    logic [NUM_BANKS-1:0][ADDR_W-1:0]  req_addr;
    logic                              wr_ok;
    logic [ADDR_W-1:0]                 wr_addr;
    logic [NUM_BANKS-1:0][WORD_W-1:0]  bank_q;
    logic [NUM_BANKS-1:0][WORD_W-1:0]  aligned;
    logic [ROT_W-1:0]                  rot_q;
    rd_status_t                        status_q;

    linebank_addr_gen #(
        .NUM_BANKS(NUM_BANKS), .NUM_REGIONS(NUM_REGIONS), .NUM_COLS(NUM_COLS),
        .LINE_W(LINE_W), .COL_W(COL_W), .ROT_W(ROT_W), .ADDR_W(ADDR_W)
    ) u_addr_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (rd_en),
        .start_line (rd_line),
        .col        (rd_col),
        .rot        (req_rot),
        .oor        (req_oor),
        .next_mask  (req_next_mask),
        .bank_addr  (req_addr)
    );

    // Purpose: decode the write line into a legality flag and an in-bank address.
    always_comb begin
        wr_ok   = wr_en && (int'(wr_line) < NUM_LINES);
        wr_addr = ADDR_W'(wr_line[LINE_W-1:ROT_W]) * ADDR_W'(NUM_COLS) + ADDR_W'(wr_col);
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        linebank_bank #(
            .WORD_W(WORD_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)
        ) u_bank (
            .clk   (clk),
            .we    (wr_ok && (wr_line[ROT_W-1:0] == ROT_W'(b))),
            .waddr (wr_addr),
            .wdata (wr_data),
            .re    (rd_en && !req_oor),
            .raddr (req_addr[b]),
            .rdata (bank_q[b])
        );
    end

    // Purpose: hold the rotate amount and status of the request in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            rot_q    <= '0;
        end else begin
            status_q.valid <= rd_en;
            status_q.oor   <= rd_en && req_oor;
            if (rd_en) begin
                rot_q <= req_rot;
            end
        end
    end

    linebank_vrot #(
        .NUM_BANKS(NUM_BANKS), .WORD_W(WORD_W), .ROT_W(ROT_W)
    ) u_vrot (
        .din  (bank_q),
        .rot  (rot_q),
        .dout (aligned)
    );

    // Purpose: drive the outputs, forcing zero data for out-of-range requests.
    always_comb begin
        rd_valid = status_q.valid;
        rd_oor   = status_q.oor;
        rd_data  = status_q.oor ? '0 : aligned;
    end

    // A request is answered in the next cycle.
    assert_valid_follows_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    // No request means no result in the next cycle.
    assert_idle_no_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    // The range flag only accompanies a result.
    assert_oor_with_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_oor |-> rd_valid);

    // Word 0 of an in-range result is the bank selected by the held rotate amount.
    assert_word0_is_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_oor) |-> (rd_data[WORD_W-1:0] == bank_q[rot_q]));

    // The rotate amount changes only when a request is accepted.
    assert_rot_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rot_q));
endmodule

// File: tb/linebank_rotator_bench.sv
// Bench: behavioural window model, compared with the outputs on every clock.
module linebank_rotator_bench;
    localparam int NB    = 16;
    localparam int LINES = 48;
    localparam int COLS  = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [5:0]   wr_line = '0;
    logic [4:0]   wr_col = '0;
    logic [15:0]  wr_data = '0;
    logic         rd_en = 1'b0;
    logic [5:0]   rd_line = '0;
    logic [4:0]   rd_col = '0;
    logic         rd_valid;
    logic         rd_oor;
    logic [255:0] rd_data;

    logic [15:0]  mdl [LINES][COLS];
    int           n_checks = 0;
    int           n_fails  = 0;
    bit           done = 1'b0;
    int unsigned  lcg = 32'h1234_5678;

    always #5 clk = ~clk;

    linebank_rotator u_linebank_rotator (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_line(wr_line), .wr_col(wr_col), .wr_data(wr_data),
        .rd_en(rd_en), .rd_line(rd_line), .rd_col(rd_col),
        .rd_valid(rd_valid), .rd_oor(rd_oor), .rd_data(rd_data)
    );

    function automatic int unsigned next_rand();
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        return lcg >> 8;
    endfunction

    task automatic check_bit(input string tag, input logic got, input logic exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %0b expected %0b", tag, got, exp);
        end
    endtask

    // One clock: drive at the falling edge, predict, update the model, compare after the rising edge.
    task automatic step(input bit we, input int wl, input int wc, input logic [15:0] wd,
                        input bit re, input int rl, input int rc, input string tag);
        logic         e_valid;
        logic         e_oor;
        logic [255:0] e_data;
        @(negedge clk);
        wr_en = we; wr_line = 6'(wl); wr_col = 5'(wc); wr_data = wd;
        rd_en = re; rd_line = 6'(rl); rd_col = 5'(rc);
        e_valid = re;
        e_oor   = re && (rl > 32);
        e_data  = '0;
        if (re && !e_oor) begin
            for (int k = 0; k < NB; k++) e_data[k*16 +: 16] = mdl[rl+k][rc];
        end
        if (we && wl < LINES) mdl[wl][wc] = wd;
        @(posedge clk);
        #1;
        check_bit({tag, " valid"}, rd_valid, e_valid);
        check_bit({tag, " oor"}, rd_oor, e_oor);
        if (e_valid) begin
            n_checks++;
            if (rd_data !== e_data) begin
                n_fails++;
                $display("FAIL %s: start %0d col %0d got %h expected %h", tag, rl, rc, rd_data, e_data);
            end
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : stimulus
        // R8: requests during reset produce no result.
        rd_en = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check_bit("R8 reset valid", rd_valid, 1'b0);
        check_bit("R8 reset oor", rd_oor, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        rd_en = 1'b0;

        // Fill the window with distinct values (R1 setup, R5 idle).
        for (int l = 0; l < LINES; l++)
            for (int c = 0; c < COLS; c++)
                step(1, l, c, 16'((l << 8) ^ (c * 37) ^ 16'h5A00), 0, 0, 0, "R5 fill");

        // R3: aligned starts.
        for (int s = 0; s <= 32; s += 16)
            for (int c = 0; c < COLS; c += 7) step(0, 0, 0, '0, 1, s, c, "R3 R1 aligned");

        // R2 R4: every in-range start, back-to-back (R9).
        for (int s = 0; s <= 32; s++) step(0, 0, 0, '0, 1, s, (s * 5) % COLS, "R2 R4 R9 sweep");
        step(0, 0, 0, '0, 1, 6, 3, "R2 rot6");
        step(0, 0, 0, '0, 1, 22, 9, "R2 R4 rot6 base1");

        // R5: idle gap.
        step(0, 0, 0, '0, 0, 0, 0, "R5 idle");
        step(0, 0, 0, '0, 0, 0, 0, "R5 idle");

        // R6: out-of-range starts and the boundary.
        step(0, 0, 0, '0, 1, 32, 4, "R6 boundary in");
        step(0, 0, 0, '0, 1, 33, 4, "R6 boundary out");
        step(0, 0, 0, '0, 1, 47, 4, "R6 out");
        step(0, 0, 0, '0, 1, 48, 4, "R6 unused code");
        step(0, 0, 0, '0, 1, 63, 4, "R6 top code");
        step(0, 0, 0, '0, 1, 10, 4, "R6 back in range");

        // R10: writes to unused lines, then read every column of the top span.
        for (int l = 48; l < 64; l++) step(1, l, l % COLS, 16'hDEAD, 0, 0, 0, "R10 ignored write");
        for (int c = 0; c < COLS; c++) step(0, 0, 0, '0, 1, 32, c, "R10 unchanged");

        // R7: same-cycle write and read of one location, then a re-read.
        for (int s = 0; s <= 32; s += 3) begin
            int k;
            int c;
            k = (s * 7) % NB;
            c = (s * 11) % COLS;
            step(1, s + k, c, 16'(16'hA000 + s), 1, s, c, "R7 old value");
            step(0, 0, 0, '0, 1, s, c, "R7 R1 new value");
        end

        // R1 R2 R9: mixed random traffic.
        for (int i = 0; i < 3000; i++) begin
            bit we;
            bit re;
            we = next_rand() % 3 == 0;
            re = next_rand() % 4 != 0;
            step(we, int'(next_rand() % 64), int'(next_rand() % COLS), 16'(next_rand()),
                 re, int'(next_rand() % 40), int'(next_rand() % COLS), "R1 R2 R9 mixed");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule